// File: doc/BRIEF.md
# Cluster Egress Bridge

The block joins a cluster's local network to the network that links clusters. Several local initiators can issue a request that has to leave the cluster. The bridge has a single crossing token, so only one such request is in flight outside the cluster at any time. A request that arrives while the token is taken, or that loses arbitration in the same cycle as another, is held back. The initiator sees its ready signal stay low, and the request is never dropped. The bridge keeps a count of these waiting cycles for each port.

When a request crosses, the bridge replaces its source identifier with the bridge's own identifier. The original source and the local port number are kept in registers until the response comes back. A response from the outer network is accepted only if its destination identifier equals the bridge identifier. The bridge then returns it to the local port that owns the token, with the original source identifier restored as its destination. Requests are blocking reads, so the token is freed only after that response has been delivered on the local side.

Top module: `cluster_egress_bridge`

## Requirements
- R1: After reset, `up_req_valid` and every bit of `loc_rsp_valid` are low, every stall counter reads zero, and the first grant goes to local port 0.
- R2: A request forwarded on the outer side carries `up_req_src` equal to the parameter `BRIDGE_ID`, and its address is the address of the granted local request, unchanged.
- R3: At most one bit of `loc_req_ready` is high in any cycle. After a grant, no other local request is accepted until the response for the granted request has appeared on `loc_rsp_valid`.
- R4: Local ports are served in round-robin order. After port k is granted, the next grant goes to the first requesting port in the order k+1, k+2, ..., wrapping from N-1 to 0.
- R5: While a local port holds `loc_req_valid` high and its `loc_req_ready` is low, its stall counter (field `stall_cnt[i*CNT_W +: CNT_W]`) rises by one per cycle and saturates at all ones. In every other cycle the counter holds its value.
- R6: One cycle after the outer side accepts a response whose `up_rsp_dst` equals `BRIDGE_ID`, exactly one bit of `loc_rsp_valid` is high for one cycle. That bit is the bit of the port that owns the token. In that cycle `loc_rsp_dst` holds the original source identifier and `loc_rsp_data` holds the response data unchanged.
- R7: A response on the outer side whose `up_rsp_dst` differs from `BRIDGE_ID` is consumed and has no effect. No local response follows it, and the bridge keeps waiting for a matching response.
- R8: While `up_req_valid` is high and `up_req_ready` is low, the outgoing request stays valid and keeps its address and source unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loc_req_valid | input | N | Per-port request valid from local initiators |
| loc_req_ready | output | N | Per-port accept; low means the port is stalled |
| loc_req_src | input | N*ID_W | Per-port source identifier |
| loc_req_addr | input | N*ADDR_W | Per-port read address |
| loc_rsp_valid | output | N | One-hot response strobe toward the owning port |
| loc_rsp_dst | output | ID_W | Restored original source identifier |
| loc_rsp_data | output | DATA_W | Response data |
| up_req_valid | output | 1 | Outgoing request valid |
| up_req_ready | input | 1 | Outer network accepts the request |
| up_req_src | output | ID_W | Rewritten source identifier (BRIDGE_ID) |
| up_req_addr | output | ADDR_W | Outgoing read address |
| up_rsp_valid | input | 1 | Response valid from outer network |
| up_rsp_ready | output | 1 | Bridge is waiting for a response |
| up_rsp_dst | input | ID_W | Response destination identifier |
| up_rsp_data | input | DATA_W | Response data |
| stall_cnt | output | N*CNT_W | Per-port saturating stall-cycle counters |

## Verification
The bench builds the bridge with four local ports, 8-bit identifiers, 16-bit addresses and data, and a 4-bit stall counter. With these widths saturation is reached after fifteen waiting cycles. The last contender in a four-way burst waits for three full transactions, so that port reaches the saturated value within a few dozen cycles. With four ports, wrap-around arbitration can be tested with two separate contender pairs. The outer side can hold off acceptance for several cycles and can inject a response with a different destination identifier before the matching one.

// File: rtl/ceb_pkg.sv
package ceb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2,
    ST_RESP = 2'd3
  } ceb_state_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ceb_rr_arb.sv
module ceb_rr_arb #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  input  logic             adv,
  output logic [N-1:0]     gnt,
  output logic [IDX_W-1:0] gnt_idx
);
  logic [IDX_W-1:0] last_q, last_d;
  logic             found;
  int               cand;

  // search starts one past the last winner and wraps
  always_comb begin
    gnt     = '0;
    gnt_idx = last_q;
    found   = 1'b0;
    cand    = 0;
    for (int off = 1; off <= int'(N); off++) begin
      cand = int'(last_q) + off;
      if (cand >= int'(N)) cand = cand - int'(N);
      if (!found && req[cand]) begin
        found     = 1'b1;
        gnt[cand] = 1'b1;
        gnt_idx   = IDX_W'(cand);
      end
    end
  end

  always_comb begin
    last_d = last_q;
    if (adv) last_d = gnt_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= IDX_W'(N - 1);
    else        last_q <= last_d;
  end
endmodule

// File: rtl/ceb_wait_ctr.sv
module ceb_wait_ctr #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stalled,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             inc_en;

  always_comb begin
    inc_en = stalled && (cnt_q != CNT_MAX);
    cnt_d  = cnt_q;
    if (inc_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/ceb_rsp_steer.sv
module ceb_rsp_steer #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic             en,
  input  logic [IDX_W-1:0] owner,
  output logic [N-1:0]     strobe
);
  always_comb begin
    strobe = '0;
    for (int p = 0; p < int'(N); p++) begin
      if (en && (owner == IDX_W'(p))) strobe[p] = 1'b1;
    end
  end
endmodule

// File: rtl/cluster_egress_bridge.sv
module cluster_egress_bridge #(
  parameter int unsigned N         = 4,
  parameter int unsigned ID_W      = 8,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CNT_W     = 16,
  parameter logic [ID_W-1:0] BRIDGE_ID = 8'hB0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        loc_req_valid,
  output logic [N-1:0]        loc_req_ready,
  input  logic [N*ID_W-1:0]   loc_req_src,
  input  logic [N*ADDR_W-1:0] loc_req_addr,
  output logic [N-1:0]        loc_rsp_valid,
  output logic [ID_W-1:0]     loc_rsp_dst,
  output logic [DATA_W-1:0]   loc_rsp_data,
  output logic                up_req_valid,
  input  logic                up_req_ready,
  output logic [ID_W-1:0]     up_req_src,
  output logic [ADDR_W-1:0]   up_req_addr,
  input  logic                up_rsp_valid,
  output logic                up_rsp_ready,
  input  logic [ID_W-1:0]     up_rsp_dst,
  input  logic [DATA_W-1:0]   up_rsp_data,
  output logic [N*CNT_W-1:0]  stall_cnt
);
  import ceb_pkg::*;

  localparam int unsigned IDX_W = idx_width(N);

  ceb_state_e        state_q, state_d;
  logic [IDX_W-1:0]  owner_q, owner_d;
  logic [ID_W-1:0]   src_q, src_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;

  logic              token_free;
  logic [N-1:0]      arb_req;
  logic [N-1:0]      arb_gnt;
  logic [IDX_W-1:0]  arb_idx;
  logic              take;
  logic              rsp_hit;
  logic              cap_req_en;
  logic              cap_rsp_en;
  logic [ID_W-1:0]   sel_src;
  logic [ADDR_W-1:0] sel_addr;

  // token is free only in idle; arbitration is gated by it
  assign token_free = (state_q == ST_IDLE);
  assign arb_req    = loc_req_valid & {N{token_free}};

  ceb_rr_arb #(.N(N), .IDX_W(IDX_W)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (arb_req),
    .adv     (take),
    .gnt     (arb_gnt),
    .gnt_idx (arb_idx)
  );

  assign take          = |arb_gnt;
  assign loc_req_ready = arb_gnt;

  always_comb begin
    sel_src  = loc_req_src[arb_idx*ID_W +: ID_W];
    sel_addr = loc_req_addr[arb_idx*ADDR_W +: ADDR_W];
  end

  assign rsp_hit    = (state_q == ST_WAIT) && up_rsp_valid && (up_rsp_dst == BRIDGE_ID);
  assign cap_req_en = take;
  assign cap_rsp_en = rsp_hit;

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (take)         state_d = ST_SEND;
      ST_SEND: if (up_req_ready) state_d = ST_WAIT;
      ST_WAIT: if (rsp_hit)      state_d = ST_RESP;
      ST_RESP:                   state_d = ST_IDLE;
      default:                   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    owner_d = owner_q;
    src_d   = src_q;
    addr_d  = addr_q;
    data_d  = data_q;
    if (cap_req_en) begin
      owner_d = arb_idx;
      src_d   = sel_src;
      addr_d  = sel_addr;
    end
    if (cap_rsp_en) data_d = up_rsp_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      owner_q <= '0;
      src_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      owner_q <= owner_d;
      src_q   <= src_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
    end
  end

  // outer side: source replaced by the bridge identifier
  assign up_req_valid = (state_q == ST_SEND);
  assign up_req_src   = BRIDGE_ID;
  assign up_req_addr  = addr_q;
  assign up_rsp_ready = (state_q == ST_WAIT);

  // local side: response steered back with the saved source restored
  ceb_rsp_steer #(.N(N), .IDX_W(IDX_W)) u_steer (
    .en     (state_q == ST_RESP),
    .owner  (owner_q),
    .strobe (loc_rsp_valid)
  );

  assign loc_rsp_dst  = src_q;
  assign loc_rsp_data = data_q;

  for (genvar g = 0; g < N; g++) begin : g_ctr
    ceb_wait_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .stalled (loc_req_valid[g] && !loc_req_ready[g]),
      .cnt     (stall_cnt[g*CNT_W +: CNT_W])
    );
  end
endmodule

// File: rtl/ceb_checker.sv
module ceb_checker #(
  parameter int unsigned N         = 4,
  parameter int unsigned ID_W      = 8,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CNT_W     = 16,
  parameter logic [ID_W-1:0] BRIDGE_ID = 8'hB0
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N-1:0]        loc_req_valid,
  input logic [N-1:0]        loc_req_ready,
  input logic [N-1:0]        loc_rsp_valid,
  input logic [DATA_W-1:0]   loc_rsp_data,
  input logic                up_req_valid,
  input logic                up_req_ready,
  input logic [ID_W-1:0]     up_req_src,
  input logic [ADDR_W-1:0]   up_req_addr,
  input logic                up_rsp_valid,
  input logic                up_rsp_ready,
  input logic [ID_W-1:0]     up_rsp_dst,
  input logic [DATA_W-1:0]   up_rsp_data,
  input logic [N*CNT_W-1:0]  stall_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  p_one_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(loc_req_ready));

  p_no_grant_in_flight_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (up_req_valid || up_rsp_ready) |-> (loc_req_ready == '0));

  p_grant_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((loc_req_ready & ~loc_req_valid) == '0));

  p_req_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (up_req_valid && !up_req_ready) |=>
      (up_req_valid && $stable(up_req_addr) && $stable(up_req_src)));

  p_src_rewrite_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (up_req_valid && up_req_ready) |-> (up_req_src == BRIDGE_ID));

  p_rsp_delivered_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (up_rsp_valid && up_rsp_ready && (up_rsp_dst == BRIDGE_ID)) |=>
      ($countones(loc_rsp_valid) == 1 && loc_rsp_data == $past(up_rsp_data)));

  p_foreign_rsp_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (up_rsp_valid && up_rsp_ready && (up_rsp_dst != BRIDGE_ID)) |=>
      (loc_rsp_valid == '0 && up_rsp_ready));

  p_rsp_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(loc_rsp_valid));

  for (genvar g = 0; g < N; g++) begin : g_cnt
    p_stall_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_req_valid[g] && !loc_req_ready[g] && stall_cnt[g*CNT_W +: CNT_W] != CNT_MAX) |=>
        (stall_cnt[g*CNT_W +: CNT_W] == $past(stall_cnt[g*CNT_W +: CNT_W]) + 1'b1));

    p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(loc_req_valid[g] && !loc_req_ready[g]) |=> $stable(stall_cnt[g*CNT_W +: CNT_W]));
  end
endmodule

bind cluster_egress_bridge ceb_checker #(
  .N(N), .ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .BRIDGE_ID(BRIDGE_ID)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .loc_req_valid (loc_req_valid),
  .loc_req_ready (loc_req_ready),
  .loc_rsp_valid (loc_rsp_valid),
  .loc_rsp_data  (loc_rsp_data),
  .up_req_valid  (up_req_valid),
  .up_req_ready  (up_req_ready),
  .up_req_src    (up_req_src),
  .up_req_addr   (up_req_addr),
  .up_rsp_valid  (up_rsp_valid),
  .up_rsp_ready  (up_rsp_ready),
  .up_rsp_dst    (up_rsp_dst),
  .up_rsp_data   (up_rsp_data),
  .stall_cnt     (stall_cnt)
);

// File: tb/cluster_egress_bridge_tb.sv
module cluster_egress_bridge_tb;
  localparam int N      = 4;
  localparam int ID_W   = 8;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 4;
  localparam logic [ID_W-1:0] BID = 8'hB0;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic                clk;
  logic                rst_n;
  logic [N-1:0]        loc_req_valid;
  logic [N-1:0]        loc_req_ready;
  logic [N*ID_W-1:0]   loc_req_src;
  logic [N*ADDR_W-1:0] loc_req_addr;
  logic [N-1:0]        loc_rsp_valid;
  logic [ID_W-1:0]     loc_rsp_dst;
  logic [DATA_W-1:0]   loc_rsp_data;
  logic                up_req_valid;
  logic                up_req_ready;
  logic [ID_W-1:0]     up_req_src;
  logic [ADDR_W-1:0]   up_req_addr;
  logic                up_rsp_valid;
  logic                up_rsp_ready;
  logic [ID_W-1:0]     up_rsp_dst;
  logic [DATA_W-1:0]   up_rsp_data;
  logic [N*CNT_W-1:0]  stall_cnt;

  cluster_egress_bridge #(
    .N(N), .ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .BRIDGE_ID(BID)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .loc_req_valid(loc_req_valid), .loc_req_ready(loc_req_ready),
    .loc_req_src(loc_req_src), .loc_req_addr(loc_req_addr),
    .loc_rsp_valid(loc_rsp_valid), .loc_rsp_dst(loc_rsp_dst), .loc_rsp_data(loc_rsp_data),
    .up_req_valid(up_req_valid), .up_req_ready(up_req_ready),
    .up_req_src(up_req_src), .up_req_addr(up_req_addr),
    .up_rsp_valid(up_rsp_valid), .up_rsp_ready(up_rsp_ready),
    .up_rsp_dst(up_rsp_dst), .up_rsp_data(up_rsp_data),
    .stall_cnt(stall_cnt)
  );

  int n_chk = 0;
  int n_fail = 0;
  int hold = 0;
  bit inject_bad = 0;
  bit outstanding = 0;
  int exp_cnt [N];

  logic [ADDR_W-1:0] q_up_addr [$];
  int                q_rsp_port [$];
  logic [ID_W-1:0]   q_rsp_dst [$];
  logic [DATA_W-1:0] q_rsp_data [$];

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DATA_W-1:0] rsp_of(input logic [ADDR_W-1:0] a);
    return {a[7:0], a[15:8]} ^ 16'h3C3C;
  endfunction

  function automatic logic [ID_W-1:0] src_of(input int p);
    return 8'h10 + 8'(p);
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // driver: raise a request on a port (called just after a rising edge)
  task automatic issue(input int p, input logic [ADDR_W-1:0] a);
    loc_req_src[p*ID_W +: ID_W]    = src_of(p);
    loc_req_addr[p*ADDR_W +: ADDR_W] = a;
    loc_req_valid[p] = 1'b1;
  endtask

  // driver: expected crossing order pushed to the scoreboard
  task automatic expect_txn(input int p, input logic [ADDR_W-1:0] a);
    q_up_addr.push_back(a);
    q_rsp_port.push_back(p);
    q_rsp_dst.push_back(src_of(p));
    q_rsp_data.push_back(rsp_of(a));
  endtask

  task automatic wait_done();
    do @(negedge clk);
    while (q_up_addr.size() != 0 || q_rsp_port.size() != 0 || loc_req_valid != '0);
    repeat (2) @(negedge clk);
  endtask

  // monitor: scoreboard compare, request retirement, stall model
  initial begin
    forever begin
      logic [N-1:0] acc;
      @(negedge clk);
      acc = loc_req_valid & loc_req_ready;
      if (rst_n) begin
        if (acc != '0) begin
          chk(!outstanding, "R3 grant while token held", acc, 0);
          chk($countones(acc) == 1, "R3 single grant", acc, 1);
          outstanding = 1'b1;
        end
        if (up_req_valid && up_req_ready) begin
          if (q_up_addr.size() == 0) chk(0, "R4 unexpected crossing", up_req_addr, 0);
          else begin
            logic [ADDR_W-1:0] ea;
            ea = q_up_addr.pop_front();
            chk(up_req_addr == ea, "R4/R2 crossing address order", up_req_addr, ea);
            chk(up_req_src == BID, "R2 source rewritten", up_req_src, BID);
          end
        end
        if (loc_rsp_valid != '0) begin
          if (q_rsp_port.size() == 0) chk(0, "R7 unexpected local response", loc_rsp_valid, 0);
          else begin
            int ep;
            logic [ID_W-1:0] ed;
            logic [DATA_W-1:0] edat;
            ep = q_rsp_port.pop_front();
            ed = q_rsp_dst.pop_front();
            edat = q_rsp_data.pop_front();
            chk(loc_rsp_valid == (N'(1) << ep), "R6 response port", loc_rsp_valid, N'(1) << ep);
            chk(loc_rsp_dst == ed, "R6 restored source", loc_rsp_dst, ed);
            chk(loc_rsp_data == edat, "R6 response data", loc_rsp_data, edat);
          end
          outstanding = 1'b0;
        end
        for (int i = 0; i < N; i++) begin
          chk(stall_cnt[i*CNT_W +: CNT_W] == CNT_W'(exp_cnt[i]), "R5 stall counter",
              stall_cnt[i*CNT_W +: CNT_W], exp_cnt[i]);
          if (loc_req_valid[i] && !loc_req_ready[i] && exp_cnt[i] < int'(CMAX))
            exp_cnt[i]++;
        end
      end
      @(posedge clk);
      #1;
      loc_req_valid = loc_req_valid & ~acc;
    end
  end

  // outer-network responder
  initial begin
    up_req_ready = 1'b0;
    up_rsp_valid = 1'b0;
    up_rsp_dst   = '0;
    up_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (rst_n && up_req_valid) begin
        logic [ADDR_W-1:0] a;
        a = up_req_addr;
        for (int k = 0; k < hold; k++) begin
          @(negedge clk);
          chk(up_req_valid && up_req_addr == a && up_req_src == BID,
              "R8 request held while not accepted", up_req_addr, a);
        end
        @(posedge clk); #1 up_req_ready = 1'b1;
        @(posedge clk); #1 up_req_ready = 1'b0;
        if (inject_bad) begin
          up_rsp_valid = 1'b1;
          up_rsp_dst   = BID + 8'd1;
          up_rsp_data  = 16'hDEAD;
          @(posedge clk); #1 up_rsp_valid = 1'b0;
          for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            chk(loc_rsp_valid == '0, "R7 foreign response ignored", loc_rsp_valid, 0);
            chk(up_rsp_ready, "R7 still waiting", up_rsp_ready, 1);
          end
          @(posedge clk); #1;
        end
        up_rsp_valid = 1'b1;
        up_rsp_dst   = BID;
        up_rsp_data  = rsp_of(a);
        @(posedge clk); #1 up_rsp_valid = 1'b0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) exp_cnt[i] = 0;
    loc_req_valid = '0;
    loc_req_src   = '0;
    loc_req_addr  = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(up_req_valid == 1'b0, "R1 up_req_valid in reset", up_req_valid, 0);
    chk(loc_rsp_valid == '0, "R1 loc_rsp_valid in reset", loc_rsp_valid, 0);
    chk(stall_cnt == '0, "R1 stall counters in reset", stall_cnt, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(up_req_valid == 1'b0, "R1 idle after reset", up_req_valid, 0);

    // R1/R4: first contenders after reset, port 0 wins over port 2
    @(posedge clk); #1;
    expect_txn(0, 16'h1200);
    expect_txn(2, 16'h3402);
    issue(2, 16'h3402);
    issue(0, 16'h1200);
    wait_done();

    // R2/R6: lone request, immediate acceptance
    @(posedge clk); #1;
    expect_txn(1, 16'hA511);
    issue(1, 16'hA511);
    wait_done();

    // R8: outer side holds off acceptance
    hold = 3;
    @(posedge clk); #1;
    expect_txn(3, 16'h0F33);
    issue(3, 16'h0F33);
    wait_done();

    // R7: foreign response injected before the matching one
    hold = 0;
    inject_bad = 1'b1;
    @(posedge clk); #1;
    expect_txn(2, 16'h7722);
    issue(2, 16'h7722);
    wait_done();
    inject_bad = 1'b0;

    // R3/R4/R5: four-way burst, last winner was port 2 -> 3,0,1,2
    hold = 2;
    @(posedge clk); #1;
    expect_txn(3, 16'h3003);
    expect_txn(0, 16'h0000);
    expect_txn(1, 16'h1001);
    expect_txn(2, 16'h2002);
    for (int p = 0; p < N; p++) issue(p, 16'h1001 * 16'(p));
    wait_done();
    @(negedge clk);
    chk(stall_cnt[2*CNT_W +: CNT_W] == CMAX, "R5 saturation on longest waiter",
        stall_cnt[2*CNT_W +: CNT_W], CMAX);

    // R4: wrap-around, last winner port 2; contenders 1 and 3 -> 3 then 1
    hold = 0;
    @(posedge clk); #1;
    expect_txn(3, 16'hC3C3);
    expect_txn(1, 16'hC1C1);
    issue(1, 16'hC1C1);
    issue(3, 16'hC3C3);
    wait_done();

    // R4: last winner port 1; contenders 0 and 2 -> 2 then 0
    @(posedge clk); #1;
    expect_txn(2, 16'hE2E2);
    expect_txn(0, 16'hE0E0);
    issue(0, 16'hE0E0);
    issue(2, 16'hE2E2);
    wait_done();

    chk(q_up_addr.size() == 0 && q_rsp_port.size() == 0, "R6 scoreboard drained",
        q_up_addr.size(), 0);
    finish_run();
  end
endmodule